// File: doc/BRIEF.md
# Masked Interrupt Priority Resolver

This block gathers a set of level-sensitive interrupt lines into a pending status field, masks that field with a local enable mask, and decides whether the core should take an interrupt. Line levels arrive through an indexed update port. Each update writes one level into one pending bit. When a request is raised, the block also reports which line won and the vectored entry address that the core should branch to.

The entry address is the base address plus (vector offset + winning index) times a stride. The stride is a power of two chosen by a small spacing code. A spacing code of zero gives a stride of zero, so every vector lands on the base address. A separate wake indication tells a sleeping core that work is waiting. The wake indication ignores the global enable and the debug flag.

Top module: `irqResolver`

## Requirements
- R1: An update with `updEn`=1 and `updIdx` in 0..12 writes `updLevel` into bit `updIdx` of `pendOut` at the next clock edge. A level of 1 sets the bit and a level of 0 clears it. All other bits keep their values.
- R2: An update whose `updIdx` is 13, 14 or 15 changes no pending bit.
- R3: `wake` is 1 exactly when the bitwise AND of `pendOut` and the local enable mask is nonzero. It follows the registered state with no extra delay. It does not depend on `globalIe` or `dbgMode`.
- R4: `takeReq` is 1 in the cycle after an edge at which three conditions held: `wake` was 1, `globalIe` was 1, and `dbgMode` was 0. In every other cycle `takeReq` is 0.
- R5: While `takeReq` is 1, `selIdx` gives the highest-numbered bit that was set in the pending-and-enabled field at the sampling edge.
- R6: While `takeReq` is 1 with a spacing code VS from 1 to 7, `targetAddr` equals `entryBase` + (64 + `selIdx`) × ((1 << VS) × 4), taken modulo 2^32. `entryBase` is the value at the sampling edge.
- R7: While `takeReq` is 1 with VS = 0, `targetAddr` equals `entryBase`.
- R8: While `takeReq` is 0, `selIdx` and `targetAddr` are both 0.
- R9: Reset clears the pending field, the enable mask and VS. After reset, `wake`, `takeReq`, `selIdx` and `targetAddr` are 0. A pending bit that is set after reset does not raise `wake` until a mask is written.
- R10: When `cfgWe`=1, `cfgMask` and `cfgVs` are loaded at the clock edge and take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| updEn | input | 1 | Pending-bit update strobe |
| updIdx | input | 4 | Line index of the update |
| updLevel | input | 1 | Level written to the pending bit |
| cfgWe | input | 1 | Load strobe for the mask and spacing code |
| cfgMask | input | 13 | New local enable mask |
| cfgVs | input | 3 | New vector spacing code |
| globalIe | input | 1 | Global interrupt enable |
| dbgMode | input | 1 | Core is in debug mode |
| entryBase | input | 32 | Entry base address |
| pendOut | output | 13 | Pending status field |
| wake | output | 1 | Pending-and-enabled interrupt present |
| takeReq | output | 1 | Take-interrupt request (registered) |
| selIdx | output | 4 | Winning line index (registered) |
| targetAddr | output | 32 | Vectored entry address (registered) |

## Verification
The hardest case to reach from the ports is a request that is blocked while `wake` is high. This needs a mask load and a pending update first, then a cycle with debug mode set or the global enable cleared. The random stimulus therefore raises debug mode about one cycle in eight and lowers the enable about one in four, while mask loads and updates build up the pending field. Directed steps cover the rest: all thirteen lines pending at once for the priority order, out-of-range indices, both VS extremes, and a reset issued while a mask is loaded.

// File: rtl/irqResolverPkg.sv
package irqResolverPkg;
  localparam int IRQ_LINES = 13;
  localparam int IDX_W     = $clog2(IRQ_LINES);
  localparam int VS_W      = 3;

  typedef struct packed {
    logic                 capture;
    logic [IRQ_LINES-1:0] hit;
  } irqStrobe_t;
endpackage

// File: rtl/irqCtrl.sv
module irqCtrl
  import irqResolverPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 updEn,
  input  logic [IDX_W-1:0]     updIdx,
  input  logic                 updLevel,
  input  logic                 cfgWe,
  input  logic [IRQ_LINES-1:0] cfgMask,
  input  logic [VS_W-1:0]      cfgVs,
  input  logic                 globalIe,
  input  logic                 dbgMode,
  output logic [IRQ_LINES-1:0] pend,
  output logic [VS_W-1:0]      vsCode,
  output logic                 wake,
  output irqStrobe_t           strb
);
  logic [IRQ_LINES-1:0] enMask;

  // one pending flop per line; indices past the top line match no bit
  for (genvar b = 0; b < IRQ_LINES; b++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pend[b] <= 1'b0;
      end else if (updEn && updIdx == IDX_W'(b)) begin
        pend[b] <= updLevel;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask <= '0;
      vsCode <= '0;
    end else if (cfgWe) begin
      enMask <= cfgMask;
      vsCode <= cfgVs;
    end
  end

  logic [IRQ_LINES-1:0] hitVec;
  assign hitVec = pend & enMask;
  assign wake   = |hitVec;

  always_comb begin
    strb.hit     = hitVec;
    strb.capture = wake && globalIe && !dbgMode;
  end
endmodule

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqResolverPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int VEC_OFS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobe_t        strb,
  input  logic [VS_W-1:0]   vsCode,
  input  logic [ADDR_W-1:0] entryBase,
  output logic              takeReq,
  output logic [IDX_W-1:0]  selIdx,
  output logic [ADDR_W-1:0] targetAddr
);
  localparam int SH_W = VS_W + 1;

  logic [IDX_W-1:0]  winner;
  logic [ADDR_W-1:0] vecNum;
  logic [SH_W-1:0]   shAmt;
  logic [ADDR_W-1:0] vecOffset;
  logic [ADDR_W-1:0] nextAddr;

  // later iterations overwrite earlier ones: the top set bit wins
  always_comb begin
    winner = '0;
    for (int i = 0; i < IRQ_LINES; i++) begin
      if (strb.hit[i]) winner = IDX_W'(i);
    end
  end

  always_comb begin
    vecNum    = ADDR_W'(VEC_OFS) + ADDR_W'(winner);
    shAmt     = SH_W'(vsCode) + SH_W'(2);
    vecOffset = (vsCode == '0) ? '0 : (vecNum << shAmt);
    nextAddr  = entryBase + vecOffset;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takeReq    <= 1'b0;
      selIdx     <= '0;
      targetAddr <= '0;
    end else if (strb.capture) begin
      takeReq    <= 1'b1;
      selIdx     <= winner;
      targetAddr <= nextAddr;
    end else begin
      takeReq    <= 1'b0;
      selIdx     <= '0;
      targetAddr <= '0;
    end
  end
endmodule

// File: rtl/irqResolver.sv
module irqResolver
  import irqResolverPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int VEC_OFS = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 updEn,
  input  logic [IDX_W-1:0]     updIdx,
  input  logic                 updLevel,
  input  logic                 cfgWe,
  input  logic [IRQ_LINES-1:0] cfgMask,
  input  logic [VS_W-1:0]      cfgVs,
  input  logic                 globalIe,
  input  logic                 dbgMode,
  input  logic [ADDR_W-1:0]    entryBase,
  output logic [IRQ_LINES-1:0] pendOut,
  output logic                 wake,
  output logic                 takeReq,
  output logic [IDX_W-1:0]     selIdx,
  output logic [ADDR_W-1:0]    targetAddr
);
  irqStrobe_t      strb;
  logic [VS_W-1:0] vsCode;

  irqCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .updEn(updEn), .updIdx(updIdx), .updLevel(updLevel),
    .cfgWe(cfgWe), .cfgMask(cfgMask), .cfgVs(cfgVs), .globalIe(globalIe),
    .dbgMode(dbgMode), .pend(pendOut), .vsCode(vsCode), .wake(wake), .strb(strb)
  );

  irqDatapath #(.ADDR_W(ADDR_W), .VEC_OFS(VEC_OFS)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .vsCode(vsCode), .entryBase(entryBase),
    .takeReq(takeReq), .selIdx(selIdx), .targetAddr(targetAddr)
  );
endmodule

// File: rtl/irqResolverChk.sv
module irqResolverChk
  import irqResolverPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 updEn,
  input logic [IDX_W-1:0]     updIdx,
  input logic                 updLevel,
  input logic                 globalIe,
  input logic                 dbgMode,
  input logic [IRQ_LINES-1:0] pendOut,
  input logic                 wake,
  input logic                 takeReq,
  input logic [IDX_W-1:0]     selIdx,
  input logic [ADDR_W-1:0]    targetAddr
);
  logic pastValid;
  always_ff @(posedge clk) pastValid <= rstN;

  a_r1_level_write: assert property (@(posedge clk) disable iff (!rstN)
    (updEn && updIdx < IDX_W'(IRQ_LINES)) |=>
      (((pendOut >> $past(updIdx)) & IRQ_LINES'(1)) == IRQ_LINES'($past(updLevel))));

  a_r2_range_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && updEn && updIdx >= IDX_W'(IRQ_LINES)) |=> $stable(pendOut));

  a_r4_gate: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && takeReq) |-> ($past(globalIe) && !$past(dbgMode) && $past(wake)));

  a_r5_sel_pending: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && takeReq) |->
      ((($past(pendOut) >> selIdx) & IRQ_LINES'(1)) != '0));

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !takeReq |-> (selIdx == '0 && targetAddr == '0));
endmodule

bind irqResolver irqResolverChk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .updEn(updEn), .updIdx(updIdx), .updLevel(updLevel),
  .globalIe(globalIe), .dbgMode(dbgMode), .pendOut(pendOut), .wake(wake),
  .takeReq(takeReq), .selIdx(selIdx), .targetAddr(targetAddr)
);

// File: tb/test_irqResolver.sv
`timescale 1ns/1ps
module test_irqResolver;
  logic        clk = 1'b0;
  logic        rstN;
  logic        updEn, updLevel, cfgWe, globalIe, dbgMode;
  logic [3:0]  updIdx;
  logic [12:0] cfgMask;
  logic [2:0]  cfgVs;
  logic [31:0] entryBase;
  logic [12:0] pendOut;
  logic        wake, takeReq;
  logic [3:0]  selIdx;
  logic [31:0] targetAddr;

  int total = 0;
  int bad   = 0;

  // bench model
  logic [12:0] mPend, mMask;
  logic [2:0]  mVs;
  logic        eTake;
  logic [3:0]  eSel;
  logic [31:0] eAddr;

  always #2 clk = ~clk;

  irqResolver i_irqResolver (
    .clk(clk), .rstN(rstN), .updEn(updEn), .updIdx(updIdx), .updLevel(updLevel),
    .cfgWe(cfgWe), .cfgMask(cfgMask), .cfgVs(cfgVs), .globalIe(globalIe),
    .dbgMode(dbgMode), .entryBase(entryBase), .pendOut(pendOut), .wake(wake),
    .takeReq(takeReq), .selIdx(selIdx), .targetAddr(targetAddr)
  );

  function automatic logic [3:0] topBit(logic [12:0] v);
    logic [3:0] r = 4'd0;
    for (int i = 0; i < 13; i++) if (v[i]) r = 4'(i);
    return r;
  endfunction

  function automatic logic [31:0] vecAddr(logic [31:0] base, logic [2:0] vs, logic [3:0] idx);
    logic [31:0] stride;
    stride = (vs == 3'd0) ? 32'd0 : (32'd4 << vs);
    return base + (32'd64 + 32'(idx)) * stride;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, predict, clock, check at next negedge
  task automatic step(logic ue, logic [3:0] ui, logic ul, logic cw, logic [12:0] cm,
                      logic [2:0] cv, logic ie, logic dbg, logic [31:0] base);
    logic [12:0] hit;
    updEn = ue; updIdx = ui; updLevel = ul; cfgWe = cw; cfgMask = cm; cfgVs = cv;
    globalIe = ie; dbgMode = dbg; entryBase = base;
    hit   = mPend & mMask;
    eTake = (hit != 13'd0) && ie && !dbg;
    eSel  = eTake ? topBit(hit) : 4'd0;
    eAddr = eTake ? vecAddr(base, mVs, topBit(hit)) : 32'd0;
    @(posedge clk);
    if (ue && ui < 4'd13) mPend[ui] = ul;
    if (cw) begin mMask = cm; mVs = cv; end
    @(negedge clk);
    chk("R1_R2 pending", 64'(pendOut), 64'(mPend));
    chk("R3 wake", 64'(wake), 64'((mPend & mMask) != 13'd0));
    chk("R4 takeReq", 64'(takeReq), 64'(eTake));
    chk("R5_R8 selIdx", 64'(selIdx), 64'(eSel));
    chk("R6_R7_R8 targetAddr", 64'(targetAddr), 64'(eAddr));
  endtask

  task automatic doReset();
    rstN = 1'b0;
    updEn = 0; updIdx = 0; updLevel = 0; cfgWe = 0; cfgMask = 0; cfgVs = 0;
    globalIe = 0; dbgMode = 0; entryBase = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mPend = '0; mMask = '0; mVs = '0;
    @(negedge clk);
    chk("R9 reset pend", 64'(pendOut), 64'd0);
    chk("R9 reset wake", 64'(wake), 64'd0);
    chk("R9 reset take", 64'(takeReq), 64'd0);
    chk("R9 reset addr", 64'(targetAddr), 64'd0);
  endtask

  initial begin : watchdog
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    doReset();
    // R9: pending bit with cleared mask gives no wake
    step(1, 4'd5, 1, 0, 13'h0, 3'd0, 1, 0, 32'h1000);
    step(0, 4'd0, 0, 0, 13'h0, 3'd0, 1, 0, 32'h1000);
    // R10: load mask and VS, then request appears
    step(0, 4'd0, 0, 1, 13'h1fff, 3'd7, 1, 0, 32'h1000);
    step(0, 4'd0, 0, 0, 13'h0, 3'd0, 1, 0, 32'h1000);
    // R5/R6: all lines pending, top line wins at max stride
    for (int i = 0; i < 13; i++) step(1, 4'(i), 1, 0, 13'h0, 3'd0, 1, 0, 32'h8000_0000);
    step(0, 4'd0, 0, 0, 13'h0, 3'd0, 1, 0, 32'hffff_fff0);
    // R2: out-of-range indices ignored
    step(1, 4'd13, 0, 0, 13'h0, 3'd0, 0, 0, 32'h0);
    step(1, 4'd14, 0, 0, 13'h0, 3'd0, 0, 0, 32'h0);
    step(1, 4'd15, 0, 0, 13'h0, 3'd0, 0, 0, 32'h0);
    // R4: debug blocks while wake stays up (R3)
    step(0, 4'd0, 0, 0, 13'h0, 3'd0, 1, 1, 32'h40);
    step(0, 4'd0, 0, 0, 13'h0, 3'd0, 0, 0, 32'h40);
    // R7: VS zero collapses to base
    step(0, 4'd0, 0, 1, 13'h0006, 3'd0, 1, 0, 32'h40);
    step(0, 4'd0, 0, 0, 13'h0, 3'd0, 1, 0, 32'h1234_5678);
    // R1: clearing a line
    step(1, 4'd2, 0, 0, 13'h0, 3'd0, 1, 0, 32'h40);
    step(0, 4'd0, 0, 0, 13'h0, 3'd0, 1, 0, 32'h40);
    // R9: reset with a live mask clears it
    doReset();
    step(1, 4'd0, 1, 0, 13'h0, 3'd0, 1, 0, 32'h0);
    step(0, 4'd0, 0, 0, 13'h0, 3'd0, 1, 0, 32'h0);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 2) == 0, 4'($urandom % 16), 1'($urandom % 2),
           ($urandom % 10) == 0, 13'($urandom), 3'($urandom % 8),
           ($urandom % 4) != 0, ($urandom % 8) == 0, $urandom);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule